// File: doc/BRIEF.md
# Zero-Suppressed Strip Hit Encoder

This block is the digital back end of a 128-channel strip readout chip. On every beam-clock strobe it takes a snapshot of the per-channel discriminator flags and 3-bit ADC codes. It keeps only the channels that fired, are not masked, and have an amplitude at or above a programmable threshold. It then packs each surviving channel into a 16-bit hit word that holds the amplitude, the strip number and a 6-bit beam-crossing stamp.

Hit words are pushed out as soon as they are found. There is no trigger input. A priority scan moves the hits of one snapshot into a small FIFO, lowest strip first, at one hit per clock. Two serial lines drain the FIFO. They run in lock-step 17-bit frames. Each frame is a flag bit followed by either a hit word or a fixed sync word, so a receiver can lock onto frame boundaries.

Consecutive hit words go to alternate lines. Hits lost to a full FIFO, or to a new snapshot arriving before the scan has finished, set a sticky overflow flag.

Top module: `strip_hit_encoder`

## Requirements
- R1: Each serial frame is 17 bits long and is sent MSB first. Frames follow one another with no gap, starting at the release of reset. A hit frame is a 1 followed by the hit word. The hit word holds the amplitude in bits [15:13], the strip number in bits [12:6] and the stamp in bits [5:0].
- R2: A channel produces a hit word only if its hit flag is 1 and its ADC code is greater than or equal to the threshold. A code of 0 with a threshold of 0 is kept.
- R3: A channel whose mask bit is 1 never produces a hit word, whatever its flag and amplitude.
- R4: The stamp counter starts at 0 after reset and advances by one on every strobe, wrapping from 63 to 0. A hit carries the counter value of the strobe that captured it, so the first strobe after reset stamps 0.
- R5: Hits captured by the same strobe are sent in ascending strip order.
- R6: Counting from reset, hit word k goes to line k mod 2, with line 0 first.
- R7: A line with no hit to send in a frame sends a 0 followed by the sync word 16'hE2A5.
- R8: Four strobes spaced 10 clocks apart, each with one hit, are all delivered with no overflow.
- R9: The overflow flag is set when a hit is lost, either because the FIFO is full or because a strobe arrives before the previous snapshot has been scanned. The flag stays set until reset.
- R10: During reset both serial lines are 0 and the overflow flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the logic and the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| bc_strobe | input | 1 | One-cycle beam-clock strobe that captures a snapshot |
| hit_flag | input | 128 | Per-channel discriminator flags |
| adc_bus | input | 384 | Per-channel 3-bit ADC codes; channel c is in bits [3c+2:3c] |
| threshold | input | 3 | Minimum amplitude that is kept |
| chan_mask | input | 128 | Per-channel suppress bits |
| ser_out | output | 2 | The two serial data lines |
| overflow | output | 1 | Sticky flag for lost hits |

## Verification
The assertions check several properties on every cycle:
- the scan order within a snapshot always rises and each picked strip is cleared;
- the stamp counter holds between strobes and wraps correctly;
- the FIFO level stays within its depth and no more is popped than is held;
- the overflow flag never clears;
- each loaded frame appears MSB first on its line.

Some behaviour can only be shown by the bench scenarios, which decode the two serial streams:
- which channels survive the threshold and mask;
- the exact content of each word;
- the even/odd split across the lines;
- the idle sync frames;
- loss under a burst of forty hits.

// File: rtl/strip_enc_pkg.sv
package strip_enc_pkg;
  localparam int ADC_W   = 3;
  localparam int STRIP_W = 7;
  localparam int BC_W    = 6;
  localparam int WORD_W  = ADC_W + STRIP_W + BC_W;

  typedef struct packed {
    logic [ADC_W-1:0]   amp;
    logic [STRIP_W-1:0] strip;
    logic [BC_W-1:0]    stamp;
  } hit_word_t;
endpackage

// File: rtl/hit_qualifier.sv
module hit_qualifier
  import strip_enc_pkg::*;
#(
  parameter int N_CH = 128
) (
  input  logic [N_CH-1:0]       hit_flag,
  input  logic [N_CH*ADC_W-1:0] adc_bus,
  input  logic [ADC_W-1:0]      threshold,
  input  logic [N_CH-1:0]       chan_mask,
  output logic [N_CH-1:0]       qual
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    assign qual[ch] = hit_flag[ch] & ~chan_mask[ch] &
                      (adc_bus[ch*ADC_W +: ADC_W] >= threshold);
  end
endmodule

// File: rtl/hit_scanner.sv
module hit_scanner
  import strip_enc_pkg::*;
#(
  parameter int N_CH = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bc_strobe,
  input  logic [N_CH-1:0]       qual,
  input  logic [N_CH*ADC_W-1:0] adc_bus,
  output logic                  pick_valid,
  output hit_word_t             pick_word,
  output logic                  lost
);
  logic [N_CH-1:0]       pending_q, pending_d, pending_rest;
  logic [N_CH*ADC_W-1:0] adc_snap_q;
  logic [BC_W-1:0]       stamp_q, stamp_d, bc_cnt_q, bc_cnt_d;
  logic [STRIP_W-1:0]    pick_idx;

  // lowest pending strip wins
  always_comb begin
    pick_idx = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (pending_q[i]) pick_idx = STRIP_W'(i);
    end
  end

  assign pick_valid      = |pending_q;
  assign pick_word.amp   = adc_snap_q[pick_idx*ADC_W +: ADC_W];
  assign pick_word.strip = pick_idx;
  assign pick_word.stamp = stamp_q;

  always_comb begin
    pending_rest = pending_q;
    if (pick_valid) pending_rest[pick_idx] = 1'b0;
    pending_d = bc_strobe ? qual : pending_rest;
    stamp_d   = bc_strobe ? bc_cnt_q : stamp_q;
    bc_cnt_d  = bc_strobe ? bc_cnt_q + 1'b1 : bc_cnt_q;
    lost      = bc_strobe & (|pending_rest);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      stamp_q   <= '0;
      bc_cnt_q  <= '0;
    end else begin
      pending_q <= pending_d;
      stamp_q   <= stamp_d;
      bc_cnt_q  <= bc_cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (bc_strobe) adc_snap_q <= adc_bus;
  end

  assert_scan_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid && !bc_strobe |=> !pick_valid || (pick_idx > $past(pick_idx)));
  assert_pick_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid && !bc_strobe |=> !pending_q[$past(pick_idx)]);
  assert_stamp_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bc_strobe && (bc_cnt_q == '1) |=> bc_cnt_q == '0);
  assert_stamp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_strobe |=> $stable(bc_cnt_q));
endmodule

// File: rtl/hit_fifo.sv
module hit_fifo #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic [1:0]   pop,
  output logic [W-1:0] rd0,
  output logic [W-1:0] rd1,
  output logic [AW:0]  level,
  output logic         full
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          push_ok;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign push_ok = push & ~full;
  assign level   = cnt_q;
  assign rd0     = mem[rd_q];
  assign rd1     = mem[AW'(rd_q + 1'b1)];

  always_comb begin
    wr_d  = push_ok ? AW'(wr_q + 1'b1) : wr_q;
    rd_d  = AW'(rd_q + AW'(pop));
    cnt_d = cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));
  assert_pop_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (AW+1)'(pop) <= cnt_q);
endmodule

// File: rtl/line_serializer.sv
module line_serializer #(
  parameter int               FRAME_W = 17,
  parameter logic [FRAME_W-1:0] IDLE  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               sdo
);
  logic [FRAME_W-1:0] sreg_q, sreg_d;

  assign sreg_d = load ? frame : {sreg_q[FRAME_W-2:0], 1'b0};
  assign sdo    = sreg_q[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= IDLE;
    else        sreg_q <= sreg_d;
  end

  assert_frame_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sdo == $past(frame[FRAME_W-1]));
endmodule

// File: rtl/strip_hit_encoder.sv
module strip_hit_encoder
  import strip_enc_pkg::*;
#(
  parameter int                N_CH      = 128,
  parameter int                FIFO_AW   = 3,
  parameter logic [WORD_W-1:0] SYNC_WORD = 16'hE2A5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bc_strobe,
  input  logic [N_CH-1:0]       hit_flag,
  input  logic [N_CH*ADC_W-1:0] adc_bus,
  input  logic [ADC_W-1:0]      threshold,
  input  logic [N_CH-1:0]       chan_mask,
  output logic [1:0]            ser_out,
  output logic                  overflow
);
  localparam int N_LINES = 2;
  localparam int FRAME_W = WORD_W + 1;
  localparam int FC_W    = $clog2(FRAME_W);
  localparam logic [FRAME_W-1:0] IDLE = {1'b0, SYNC_WORD};

  logic [N_CH-1:0]   qual;
  logic              pick_valid, lost, fifo_full;
  hit_word_t         pick_word;
  logic [WORD_W-1:0] rd0, rd1;
  logic [FIFO_AW:0]  level;
  logic [1:0]        pop_n;
  logic              has1, has2, frame_end;
  logic              ptr_q, ptr_d, ovf_q, ovf_d;
  logic [FC_W-1:0]   fcnt_q, fcnt_d;

  hit_qualifier #(.N_CH(N_CH)) u_qual (
    .hit_flag(hit_flag), .adc_bus(adc_bus), .threshold(threshold),
    .chan_mask(chan_mask), .qual(qual)
  );

  hit_scanner #(.N_CH(N_CH)) u_scan (
    .clk(clk), .rst_n(rst_n), .bc_strobe(bc_strobe), .qual(qual),
    .adc_bus(adc_bus), .pick_valid(pick_valid), .pick_word(pick_word),
    .lost(lost)
  );

  hit_fifo #(.W(WORD_W), .AW(FIFO_AW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(pick_valid), .din(pick_word),
    .pop(pop_n), .rd0(rd0), .rd1(rd1), .level(level), .full(fifo_full)
  );

  always_comb begin
    frame_end = (fcnt_q == FC_W'(FRAME_W - 1));
    fcnt_d    = frame_end ? '0 : fcnt_q + 1'b1;
    has1      = (level != '0);
    has2      = (level >= (FIFO_AW+1)'(2));
    pop_n     = !frame_end ? 2'd0 : has2 ? 2'd2 : has1 ? 2'd1 : 2'd0;
    ptr_d     = (pop_n == 2'd1) ? ~ptr_q : ptr_q;
    ovf_d     = ovf_q | (pick_valid & fifo_full) | lost;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      ptr_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      fcnt_q <= fcnt_d;
      ptr_q  <= ptr_d;
      ovf_q  <= ovf_d;
    end
  end

  assign overflow = ovf_q;

  for (genvar ln = 0; ln < N_LINES; ln++) begin : g_line
    logic               first, gets;
    logic [FRAME_W-1:0] frame;
    assign first = (ptr_q == 1'(ln));
    assign gets  = first ? has1 : has2;
    assign frame = gets ? {1'b1, (first ? rd0 : rd1)} : IDLE;
    line_serializer #(.FRAME_W(FRAME_W), .IDLE(IDLE)) u_ser (
      .clk(clk), .rst_n(rst_n), .load(frame_end), .frame(frame),
      .sdo(ser_out[ln])
    );
  end

  assert_sticky_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_frame_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> fcnt_q == '0);
endmodule

// File: tb/strip_hit_encoder_bench.sv
module strip_hit_encoder_bench;
  localparam int N_CH = 128;
  localparam logic [15:0] SYNC = 16'hE2A5;

  typedef struct packed {
    logic [2:0] thr;
    logic [6:0] s0;
    logic [2:0] a0;
    logic [6:0] s1;
    logic [2:0] a1;
    logic       m1;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 7'd5,   3'd3, 7'd2,   3'd1, 1'b0},
    '{3'd4, 7'd10,  3'd4, 7'd20,  3'd3, 1'b0},
    '{3'd4, 7'd30,  3'd7, 7'd31,  3'd6, 1'b1},
    '{3'd1, 7'd0,   3'd1, 7'd127, 3'd7, 1'b0},
    '{3'd7, 7'd64,  3'd6, 7'd65,  3'd7, 1'b0},
    '{3'd2, 7'd100, 3'd2, 7'd99,  3'd2, 1'b0},
    '{3'd3, 7'd40,  3'd2, 7'd41,  3'd1, 1'b0},
    '{3'd0, 7'd77,  3'd0, 7'd12,  3'd0, 1'b1}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                bc_strobe = 1'b0;
  logic [N_CH-1:0]     hit_flag = '0;
  logic [N_CH*3-1:0]   adc_bus = '0;
  logic [2:0]          threshold = '0;
  logic [N_CH-1:0]     chan_mask = '0;
  logic [1:0]          ser_out;
  logic                overflow;

  int n_chk = 0, n_bad = 0;
  logic [5:0]  stamp = '0;
  logic [15:0] exp_w [64];
  string       exp_t [64];
  int          n_exp = 0;
  logic [15:0] rx0 [256];
  logic [15:0] rx1 [256];
  int          n_rx0 = 0, n_rx1 = 0, n_idle = 0, n_bad_idle = 0;
  bit          rx_on = 1'b0;

  always #5 clk = ~clk;

  strip_hit_encoder u_strip_hit_encoder (
    .clk(clk), .rst_n(rst_n), .bc_strobe(bc_strobe), .hit_flag(hit_flag),
    .adc_bus(adc_bus), .threshold(threshold), .chan_mask(chan_mask),
    .ser_out(ser_out), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic rx_run();
    logic [16:0] s0, s1;
    int nb = 0;
    s0 = '0; s1 = '0;
    while (rx_on) begin
      s0 = {s0[15:0], ser_out[0]};
      s1 = {s1[15:0], ser_out[1]};
      nb++;
      if (nb == 17) begin
        nb = 0;
        if (s0[16]) begin rx0[n_rx0] = s0[15:0]; n_rx0++; end
        else if (s0[15:0] == SYNC) n_idle++;
        else n_bad_idle++;
        if (s1[16]) begin rx1[n_rx1] = s1[15:0]; n_rx1++; end
        else if (s1[15:0] == SYNC) n_idle++;
        else n_bad_idle++;
      end
      @(negedge clk);
    end
  endtask

  task automatic add_exp(input logic [6:0] s, input logic [2:0] a, input string t);
    exp_w[n_exp] = {a, s, stamp};
    exp_t[n_exp] = t;
    n_exp++;
  endtask

  // inputs already driven at a negedge; strobe for one clock
  task automatic fire();
    bc_strobe = 1'b1;
    @(negedge clk);
    bc_strobe = 1'b0;
    hit_flag  = '0;
    chan_mask = '0;
    adc_bus[50*3 +: 3] = 3'd7;
    stamp = stamp + 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    adc_bus[50*3 +: 3] = 3'd7;   // fires with flag 0: never reported (R2)
    repeat (3) @(negedge clk);
    check(ser_out == 2'b00, "R10 lines in reset", ser_out, 0);
    check(overflow == 1'b0, "R10 overflow in reset", overflow, 0);
    rst_n = 1'b1;
    rx_on = 1'b1;
    fork rx_run(); join_none
    @(negedge clk);
    repeat (60) @(negedge clk);
    check(n_idle > 0 && n_rx0 == 0 && n_rx1 == 0, "R7 idle after reset", n_idle, 1);

    // table of strobes with two candidate hits each
    for (int v = 0; v < 8; v++) begin
      vec_t e;
      bit q0, q1;
      e = VECS[v];
      threshold = e.thr;
      hit_flag[e.s0] = 1'b1; adc_bus[e.s0*3 +: 3] = e.a0;
      hit_flag[e.s1] = 1'b1; adc_bus[e.s1*3 +: 3] = e.a1;
      chan_mask[e.s1] = e.m1;
      q0 = (e.a0 >= e.thr);
      q1 = !e.m1 && (e.a1 >= e.thr);
      if (q0 && q1 && e.s1 < e.s0) begin
        add_exp(e.s1, e.a1, "R1 R2 R3 R5 R6");
        add_exp(e.s0, e.a0, "R1 R2 R3 R5 R6");
      end else begin
        if (q0) add_exp(e.s0, e.a0, "R1 R2 R3 R5 R6");
        if (q1) add_exp(e.s1, e.a1, "R1 R2 R3 R5 R6");
      end
      fire();
      repeat (39) @(negedge clk);
    end

    // sustained: one hit per strobe, strobes 10 clocks apart
    threshold = 3'd0;
    for (int k = 0; k < 4; k++) begin
      hit_flag[10+k] = 1'b1; adc_bus[(10+k)*3 +: 3] = 3'd5;
      add_exp(7'(10+k), 3'd5, "R8");
      fire();
      repeat (9) @(negedge clk);
    end

    // stamp wrap: 60 empty strobes, then one hit on the top strip
    for (int k = 0; k < 60; k++) begin
      fire();
      @(negedge clk);
    end
    hit_flag[127] = 1'b1; adc_bus[127*3 +: 3] = 3'd6;
    add_exp(7'd127, 3'd6, "R4");
    fire();
    repeat (200) @(negedge clk);

    check(overflow == 1'b0, "R8 no loss", overflow, 0);
    check(n_rx0 == (n_exp + 1) / 2, "R6 line0 count", n_rx0, (n_exp + 1) / 2);
    check(n_rx1 == n_exp / 2, "R6 line1 count", n_rx1, n_exp / 2);
    for (int i = 0; i < n_exp; i++) begin
      logic [15:0] got;
      got = (i % 2 == 0) ? rx0[i/2] : rx1[i/2];
      check(got == exp_w[i], exp_t[i], got, exp_w[i]);
    end
    check(exp_w[n_exp-1][5:0] == 6'd8, "R4 wrapped stamp", exp_w[n_exp-1][5:0], 8);
    check(n_bad_idle == 0, "R7 sync word", n_bad_idle, 0);

    // burst of forty hits overruns the FIFO
    begin
      int base;
      base = n_rx0 + n_rx1;
      for (int c = 0; c < 40; c++) begin
        hit_flag[c] = 1'b1; adc_bus[c*3 +: 3] = 3'd7;
      end
      fire();
      repeat (400) @(negedge clk);
      check(overflow == 1'b1, "R9 overflow set", overflow, 1);
      check((n_rx0 + n_rx1 - base) < 40, "R9 hits dropped", n_rx0 + n_rx1 - base, 39);
      fire();
      repeat (40) @(negedge clk);
      check(overflow == 1'b1, "R9 overflow sticky", overflow, 1);
    end

    rx_on = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(overflow == 1'b0, "R10 overflow cleared", overflow, 0);
    check(ser_out == 2'b00, "R10 lines idle", ser_out, 0);
    finish_run();
  end
endmodule